// File: doc/BRIEF.md
# SPI Master Slave-Select Controller

This block holds the select-enable setting of an SPI master and turns it into an active-low slave-select line. A host sets or clears a single enable bit through a small register bus. The stored bit does not drive the pin by itself. The controller samples the bit when the transfer engine signals the start of a serial transfer, pulls the select line low if the bit is set, and releases the line when the engine signals the end of the transfer.

Register access depends on the controller's state. When the device is strapped as a serial slave, writes are discarded, reads return zero and the select line stays high. While the transfer engine reports busy, writes are discarded. Clearing the bit in the middle of a transfer does not cut that transfer short.

Top module: `spi_ss_ctrl`

## Requirements
- R1: After reset the enable bit is 0, `ss_no` is 1 and `rd_data_o` is 0.
- R2: A write to the select address in master mode while not busy stores `wr_data_i[0]`. A read of that address in master mode returns `{31'b0, enable}` on `rd_data_o` in the cycle after `rd_en_i`. `rd_data_o` is 0 in any cycle that follows a cycle without a read.
- R3: Bits 31:1 of `rd_data_o` are always 0, whatever value was written.
- R4: A write to the enable bit alone never changes `ss_no`.
- R5: When `xfer_start_i` is high in master mode while the stored bit is 1 and no end strobe is present, `ss_no` goes low in the next cycle.
- R6: When `xfer_start_i` is high while the stored bit is 0, `ss_no` stays high.
- R7: When `xfer_end_i` is high, `ss_no` is 1 in the next cycle. An end strobe in the same cycle as a start strobe wins.
- R8: Clearing the enable bit during an active transfer keeps `ss_no` low until the end strobe arrives.
- R9: While `slave_mode_i` is 1, writes leave the enable bit unchanged and reads return 0.
- R10: While `busy_i` is 1, writes leave the enable bit unchanged.
- R11: While `slave_mode_i` is 1, `ss_no` is 1 from the next cycle onward and start strobes are ignored.
- R12: Writes to any address other than `SEL_ADDR` are ignored, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slave_mode_i | input | 1 | 1 = device configured as serial slave |
| busy_i | input | 1 | Transfer engine busy flag |
| xfer_start_i | input | 1 | One-cycle strobe when a serial transfer begins |
| xfer_end_i | input | 1 | One-cycle strobe when a serial transfer completes |
| wr_en_i | input | 1 | Register write enable |
| rd_en_i | input | 1 | Register read enable |
| addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read data, one cycle after `rd_en_i` |
| ss_no | output | 1 | Slave-select output, active low |

## Verification
The hardest case to reach from the ports is a transfer that is open while `busy_i` is low, so that the host can clear the enable bit in the middle of the transfer. A real engine holds busy high for the whole transfer, and that would block the write. The bench drives busy and the strobes independently, so directed steps open a transfer with busy low, clear the bit, and confirm the line stays low until the end strobe arrives. Random cycles then mix slave-mode changes, overlapping start and end strobes, and write attempts while busy, and check each cycle against a bench model.

// File: rtl/spi_ss_pkg.sv
package spi_ss_pkg;
  localparam int unsigned EN_BIT = 0;

  function automatic logic addr_hit(input logic [31:0] a, input logic [31:0] sel);
    return a == sel;
  endfunction
endpackage

// File: rtl/spi_ss_reg.sv
module spi_ss_reg
  import spi_ss_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              busy_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sel_en_o
);
  localparam int unsigned RSVD_W = DATA_W - 1;

  logic hit, wr_ok, rd_ok;
  logic en_q;
  logic [DATA_W-1:0] rd_q;

  assign hit   = addr_hit(32'(addr_i), 32'(SEL_ADDR));
  assign wr_ok = wr_en_i && hit && !slave_mode_i && !busy_i;
  assign rd_ok = rd_en_i && hit && !slave_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    en_q <= 1'b0;
    else if (wr_ok) en_q <= wr_data_i[EN_BIT];
  end

  // one-cycle read latency; idle cycles return zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    rd_q <= '0;
    else if (rd_ok) rd_q <= {{RSVD_W{1'b0}}, en_q};
    else            rd_q <= '0;
  end

  assign rd_data_o = rd_q;
  assign sel_en_o  = en_q;

  AST_SLAVE_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |=> $stable(sel_en_o)); // R9
  AST_SLAVE_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |=> rd_data_o == '0); // R9
  AST_BUSY_WR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(sel_en_o)); // R10
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:1] == '0); // R3
  AST_NO_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rd_data_o == '0); // R2
endmodule

// File: rtl/spi_ss_drive.sv
module spi_ss_drive (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic slave_mode_i,
  input  logic sel_en_i,
  input  logic xfer_start_i,
  input  logic xfer_end_i,
  output logic ss_no
);
  logic act_q;

  // end and slave mode dominate; enable is sampled only at start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        act_q <= 1'b0;
    else if (slave_mode_i || xfer_end_i) act_q <= 1'b0;
    else if (xfer_start_i && sel_en_i)  act_q <= 1'b1;
  end

  assign ss_no = ~act_q;

  AST_FALL_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_no) |-> $past(xfer_start_i && sel_en_i)); // R5
  AST_RISE_NEEDS_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_no) |-> $past(xfer_end_i || slave_mode_i)); // R8
  AST_END_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_end_i |=> ss_no); // R7
  AST_SLAVE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slave_mode_i |=> ss_no); // R11
endmodule

// File: rtl/spi_ss_ctrl.sv
module spi_ss_ctrl #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = 32,
  parameter logic [ADDR_W-1:0] SEL_ADDR = 8'h10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slave_mode_i,
  input  logic              busy_i,
  input  logic              xfer_start_i,
  input  logic              xfer_end_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ss_no
);
  logic sel_en;

  spi_ss_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_ADDR(SEL_ADDR)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slave_mode_i (slave_mode_i),
    .busy_i       (busy_i),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .sel_en_o     (sel_en)
  );

  spi_ss_drive u_drive (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .slave_mode_i (slave_mode_i),
    .sel_en_i     (sel_en),
    .xfer_start_i (xfer_start_i),
    .xfer_end_i   (xfer_end_i),
    .ss_no        (ss_no)
  );

  AST_WR_NO_PIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!xfer_start_i && !xfer_end_i && !slave_mode_i) |=> $stable(ss_no)); // R4
endmodule

// File: tb/spi_ss_ctrl_test.sv
module spi_ss_ctrl_test;
  localparam int unsigned AW = 8;
  localparam int unsigned DW = 32;
  localparam logic [AW-1:0] SEL = 8'h10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slave = 0, busy = 0, st = 0, en_end = 0, we = 0, re = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic ss_n;

  int checks = 0, errors = 0;
  logic m_en = 0, m_act = 0;
  logic [DW-1:0] m_rd = '0;

  always #2 clk = ~clk;

  spi_ss_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SEL_ADDR(SEL)) uut (
    .clk_i(clk), .rst_ni(rst_n), .slave_mode_i(slave), .busy_i(busy),
    .xfer_start_i(st), .xfer_end_i(en_end), .wr_en_i(we), .rd_en_i(re),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata), .ss_no(ss_n));

  function automatic logic nxt_en(logic e);
    return (we && addr == SEL && !slave && !busy) ? wdata[0] : e;
  endfunction
  function automatic logic nxt_act(logic a);
    if (slave || en_end) return 1'b0;
    if (st && m_en) return 1'b1;
    return a;
  endfunction
  function automatic logic [DW-1:0] nxt_rd();
    return (re && addr == SEL && !slave) ? {{(DW-1){1'b0}}, m_en} : '0;
  endfunction

  task automatic chk(string tag);
    checks++;
    if (ss_n !== ~m_act) begin
      errors++;
      $display("FAIL %s ss_no act=%b exp=%b", tag, ss_n, ~m_act);
    end
    checks++;
    if (rdata !== m_rd) begin
      errors++;
      $display("FAIL %s rd_data act=%h exp=%h", tag, rdata, m_rd);
    end
  endtask

  task automatic step(logic sl, logic bs, logic s, logic e, logic w, logic r,
                      logic [AW-1:0] a, logic [DW-1:0] d, string tag);
    slave = sl; busy = bs; st = s; en_end = e; we = w; re = r; addr = a; wdata = d;
    @(posedge clk);
    begin
      logic ne, na;
      logic [DW-1:0] nr;
      ne = nxt_en(m_en); na = nxt_act(m_act); nr = nxt_rd();
      m_en = ne; m_act = na; m_rd = nr;
    end
    @(negedge clk);
    chk(tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, '0, '0, tag);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1");
    rst_n = 1'b1;
    idle("R1");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R1");
    // write 1, pin untouched
    step(0, 0, 0, 0, 1, 0, SEL, 32'h1, "R4");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R2");
    step(0, 0, 0, 0, 1, 0, SEL, 32'hFFFF_FFFF, "R4");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R3");
    idle("R2");
    // transfer with clear in the middle
    step(0, 0, 1, 0, 0, 0, '0, '0, "R5");
    step(0, 0, 0, 0, 1, 0, SEL, 32'h0, "R8");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R8");
    idle("R8");
    step(0, 0, 0, 1, 0, 0, '0, '0, "R7");
    // start with bit clear
    step(0, 0, 1, 0, 0, 0, '0, '0, "R6");
    idle("R6");
    // busy blocks write
    step(0, 1, 0, 0, 1, 0, SEL, 32'h1, "R10");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R10");
    // slave mode access
    step(1, 0, 0, 0, 1, 0, SEL, 32'h1, "R9");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R9");
    step(0, 0, 0, 0, 1, 0, SEL, 32'h1, "R2");
    step(1, 0, 0, 0, 0, 1, SEL, '0, "R9");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R2");
    // slave mode pin control
    step(1, 0, 1, 0, 0, 0, '0, '0, "R11");
    step(0, 0, 1, 0, 0, 0, '0, '0, "R5");
    step(1, 0, 0, 0, 0, 0, '0, '0, "R11");
    // start and end together
    step(0, 0, 1, 1, 0, 0, '0, '0, "R7");
    // other address
    step(0, 0, 0, 0, 1, 0, SEL + 8'h4, 32'h0, "R12");
    step(0, 0, 0, 0, 0, 1, SEL + 8'h4, '0, "R12");
    step(0, 0, 0, 0, 0, 1, SEL, '0, "R12");
    // random mix
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] a;
      a = ($urandom_range(0, 1) != 0) ? SEL : AW'($urandom());
      step($urandom_range(0, 9) == 0, $urandom_range(0, 2) == 0,
           $urandom_range(0, 5) == 0, $urandom_range(0, 6) == 0,
           $urandom_range(0, 2) == 0, $urandom_range(0, 1) != 0,
           a, $urandom(), "R2");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule